// File: doc/BRIEF.md
# Line Clock Frequency Lock Detector

This block decides whether a recovered line clock can be trusted. It runs on a local reference clock at the nominal line rate. Each change of level on a line-derived toggle input counts as one line event. At the nominal rate there is one event every four reference cycles. The block counts these events over fixed windows and compares the count with the nominal value. From the result it chooses one of two modes.

- **Training mode:** a loss-of-lock flag is raised, and the clock-source select points at the reference clock.
- **Recovery mode:** the flag is cleared, and the select points at the line-tracked clock.

The controller has three named states:

- **ST_TRAIN:** unlocked. Both the reset state and the fallback state.
- **ST_ARMED:** one good window has been seen, but the block is still reported as unlocked.
- **ST_LOCKED:** recovery mode.

The transitions are:

- **qualify:** ST_TRAIN to ST_ARMED, on an in-range window.
- **confirm:** ST_ARMED to ST_LOCKED, on a second consecutive in-range window.
- **reject:** ST_ARMED or ST_LOCKED to ST_TRAIN, on an out-of-range window.
- **force:** any state to ST_TRAIN at once, on a fault. A fault is either an asserted loss-of-signal input or a line that stays silent for too long.

Downstream glitch-free clock switching uses the select. The select is registered in the reference domain and moves only at window ends.

Top module: `freq_lock_det`

## Requirements
- R1: After reset, `lol_o` is 1, `mode_o` is 0 (training) and `clk_sel_o` is 0 (reference clock).
- R2: Every transition of `line_tgl_i` is one event. It passes through a two-flop synchronizer, then a change detector. Events are counted over windows of 8192 reference cycles. A window is in range when its count lies within 2048 ± 10, which is about ±0.49%.
- R3: The block enters recovery mode (`mode_o`=1, `lol_o`=0) only at the end of the second of two consecutive in-range windows. After a single in-range window it still reports training.
- R4: An out-of-range window returns the block to training at that window's end. This holds from both the armed state and the locked state.
- R5: A 1 on `los_i` forces training three reference cycles after the edge that samples it: two synchronizer stages plus the state register. The block does not wait for the window to end.
- R6: If no line event is seen for 64 reference cycles, the block enters training immediately.
- R7: `clk_sel_o` changes only on the cycle after a window ends. At that point it is set to 1 (line clock) exactly when the block is in recovery mode after that boundary. After a mid-window fault it therefore stays at its old value until the next window end.
- R8: `lol_o` is always the inverse of `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock at nominal line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tgl_i | input | 1 | Line-derived toggle; each transition is one line event |
| los_i | input | 1 | Loss of signal, asynchronous, active high |
| lol_o | output | 1 | Loss-of-lock flag, 1 in training |
| clk_sel_o | output | 1 | Clock-source select: 0 reference, 1 line |
| mode_o | output | 1 | Current mode: 0 training, 1 recovery |

## Verification
The hardest case to reach from the ports is a single window whose count sits just inside or just outside the ±10 tolerance. Such a window must follow a locked state so that it can either hold lock or break it. The stimulus drives the toggle from a fractional phase accumulator. This holds the event rate at exactly +0.3%, +1% or −1% for a whole window, so the boundary count is known in advance. A loss-of-signal pulse and a line stoppage are each placed mid-window while the block is locked. This separates the immediate fall to training from the select, which waits for the next window end.

// File: rtl/flk_pkg.sv
package flk_pkg;
    typedef enum logic [1:0] {
        ST_TRAIN  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } lock_st_e;
endpackage

// File: rtl/flk_sync.sv
// Multi-stage synchronizer with a change detector on the synchronized level.
module flk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic chg_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    assign q_o   = sh_q[STAGES-1];
    assign chg_o = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/flk_meter.sv
// Window counter, event counter with range test, and silence timer.
module flk_meter #(
    parameter int WIN_CYC = 8192,
    parameter int NOM_CNT = 2048,
    parameter int TOL     = 10,
    parameter int TMO     = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic win_end_o,
    output logic in_range_o,
    output logic quiet_to_o
);
    localparam int WIN_W = $clog2(WIN_CYC);
    localparam int CNT_W = $clog2(2 * NOM_CNT + 1);
    localparam int Q_W   = $clog2(TMO + 1);
    localparam logic [CNT_W:0] LO_LIM = (CNT_W+1)'(NOM_CNT - TOL);
    localparam logic [CNT_W:0] HI_LIM = (CNT_W+1)'(NOM_CNT + TOL);

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] evt_cnt_q;
    logic [Q_W-1:0]   quiet_q;
    logic [CNT_W:0]   meas;

    assign win_end_o  = (win_q == WIN_W'(WIN_CYC - 1));
    assign meas       = {1'b0, evt_cnt_q} + {{CNT_W{1'b0}}, evt_i};
    assign in_range_o = (meas >= LO_LIM) && (meas <= HI_LIM);
    assign quiet_to_o = (quiet_q >= Q_W'(TMO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (win_end_o) begin
            win_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_cnt_q <= '0;
        end else if (win_end_o) begin
            evt_cnt_q <= {{(CNT_W-1){1'b0}}, evt_i};
        end else if (evt_i && (evt_cnt_q != {CNT_W{1'b1}})) begin
            evt_cnt_q <= evt_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (evt_i) begin
            quiet_q <= '0;
        end else if (!quiet_to_o) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R6
    quiet_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= Q_W'(TMO));

    // R2
    win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> (evt_cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/flk_ctrl.sv
// Lock state machine and registered outputs.
module flk_ctrl
    import flk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_end_i,
    input  logic in_range_i,
    input  logic fault_i,
    output logic lol_o,
    output logic mode_o,
    output logic sel_o
);
    lock_st_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRAIN;
        else        state_q <= state_d;
    end

    // Next-state logic: force, qualify, confirm, reject.
    always_comb begin
        state_d = state_q;
        if (fault_i) begin
            state_d = ST_TRAIN;
        end else if (win_end_i) begin
            unique case (state_q)
                ST_TRAIN:  state_d = in_range_i ? ST_ARMED  : ST_TRAIN;
                ST_ARMED:  state_d = in_range_i ? ST_LOCKED : ST_TRAIN;
                ST_LOCKED: state_d = in_range_i ? ST_LOCKED : ST_TRAIN;
                default:   state_d = ST_TRAIN;
            endcase
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lol_o  <= 1'b1;
            mode_o <= 1'b0;
            sel_o  <= 1'b0;
        end else begin
            lol_o  <= (state_d != ST_LOCKED);
            mode_o <= (state_d == ST_LOCKED);
            if (win_end_i) sel_o <= (state_d == ST_LOCKED);
        end
    end

    // R5
    fault_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (lol_o && !mode_o));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end_i |=> $stable(sel_o));

    // R3
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o) |-> $past(win_end_i && in_range_i && state_q == ST_ARMED));

    // R4
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && !in_range_i) |=> !mode_o);
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
    parameter int WIN_CYC   = 8192,
    parameter int NOM_CNT   = 2048,
    parameter int TOL       = 10,
    parameter int TMO       = 64,
    parameter int SYNC_STG  = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic line_tgl_i,
    input  logic los_i,
    output logic lol_o,
    output logic clk_sel_o,
    output logic mode_o
);
    logic line_lvl, line_evt;
    logic los_s, los_chg;
    logic win_end, in_range, quiet_to, fault;

    flk_sync #(.STAGES(SYNC_STG)) u_line_sync (
        .clk(ref_clk), .rst_n(rst_n), .d_i(line_tgl_i),
        .q_o(line_lvl), .chg_o(line_evt)
    );

    flk_sync #(.STAGES(SYNC_STG)) u_los_sync (
        .clk(ref_clk), .rst_n(rst_n), .d_i(los_i),
        .q_o(los_s), .chg_o(los_chg)
    );

    flk_meter #(.WIN_CYC(WIN_CYC), .NOM_CNT(NOM_CNT), .TOL(TOL), .TMO(TMO)) u_meter (
        .clk(ref_clk), .rst_n(rst_n), .evt_i(line_evt),
        .win_end_o(win_end), .in_range_o(in_range), .quiet_to_o(quiet_to)
    );

    assign fault = los_s | quiet_to;

    flk_ctrl u_ctrl (
        .clk(ref_clk), .rst_n(rst_n),
        .win_end_i(win_end), .in_range_i(in_range), .fault_i(fault),
        .lol_o(lol_o), .mode_o(mode_o), .sel_o(clk_sel_o)
    );

    // R8
    lol_mode_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lol_o != mode_o) |=> (lol_o != mode_o));

    logic unused_lvl;
    assign unused_lvl = line_lvl ^ los_chg;
endmodule

// File: tb/tb_freq_lock_det.sv
`timescale 1ns/1ps
module tb_freq_lock_det;
    localparam int K = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tgl = 1'b0;
    logic los = 1'b0;
    logic lol, sel, mode;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int line_on = 0;
    int rate = 1000000;
    longint acc = 0;

    // behavioural reference model
    int m_hist[$];
    int m_lhist[$];
    int m_quiet, m_win, m_cnt, m_st, m_sel;

    always #4 clk = ~clk;

    freq_lock_det dut (
        .ref_clk(clk), .rst_n(rst_n), .line_tgl_i(tgl), .los_i(los),
        .lol_o(lol), .clk_sel_o(sel), .mode_o(mode)
    );

    task automatic model_reset();
        m_hist = '{0, 0, 0};
        m_lhist = '{0, 0};
        m_quiet = 0; m_win = 0; m_cnt = 0; m_st = 0; m_sel = 0;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t cyc=%0d actual=%0d expected=%0d", tag, $time, cyc, act, exp);
        end
    endtask

    // per-clock comparison, stimulus drive and model step
    always @(negedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int evt, fault, wend, meas, inr, nst;
            chk(lol,  (m_st != 2) ? 1 : 0, "R8 lol vs model");
            chk(mode, (m_st == 2) ? 1 : 0, "R3 mode vs model");
            chk(sel,  m_sel, "R7 sel vs model");
            if (line_on != 0) begin
                acc += rate;
                if (acc >= 4000000) begin
                    acc -= 4000000;
                    tgl = ~tgl;
                end
            end
            evt   = m_hist[1] ^ m_hist[2];
            fault = (m_lhist[1] != 0 || m_quiet >= 64) ? 1 : 0;
            wend  = (m_win == K - 1) ? 1 : 0;
            meas  = m_cnt + evt;
            inr   = (meas >= 2038 && meas <= 2058) ? 1 : 0;
            nst = m_st;
            if (fault != 0) nst = 0;
            else if (wend != 0) nst = (inr != 0) ? ((m_st == 0) ? 1 : 2) : 0;
            if (wend != 0) m_sel = (nst == 2) ? 1 : 0;
            m_st = nst;
            void'(m_hist.pop_back());
            m_hist.push_front(int'(tgl));
            void'(m_lhist.pop_back());
            m_lhist.push_front(int'(los));
            m_quiet = (evt != 0) ? 0 : ((m_quiet < 64) ? m_quiet + 1 : 64);
            if (wend != 0) m_cnt = evt;
            else if (evt != 0 && m_cnt != 8191) m_cnt = m_cnt + 1;
            m_win = (wend != 0) ? 0 : m_win + 1;
            cyc++;
        end
    end

    // returns just after rising edge number k since reset release
    task automatic at_edge(input int k);
        while (cyc < k) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        at_edge(1);
        chk(lol, 1, "R1 lol"); chk(mode, 0, "R1 mode"); chk(sel, 0, "R1 sel");
        at_edge(100);
        chk(lol, 1, "R6 silent line");
        line_on = 1;
        at_edge(K);
        chk(mode, 0, "R2 partial window");
        at_edge(2*K);
        chk(mode, 0, "R3 one window"); chk(lol, 1, "R3 lol one window");
        at_edge(3*K - 1);
        chk(sel, 0, "R7 before boundary");
        at_edge(3*K);
        chk(mode, 1, "R3 locked"); chk(lol, 0, "R8 lol locked"); chk(sel, 1, "R7 sel line");
        rate = 1003000;
        at_edge(4*K);
        chk(mode, 1, "R2 +0.3% holds");
        rate = 1010000;
        at_edge(5*K);
        chk(mode, 0, "R4 +1% drops"); chk(sel, 0, "R7 sel ref");
        rate = 1000000;
        at_edge(7*K);
        chk(mode, 1, "R3 relock");
        rate = 990000;
        at_edge(8*K);
        chk(mode, 0, "R4 -1% drops");
        rate = 1000000;
        at_edge(10*K);
        chk(mode, 1, "R3 relock 2");
        at_edge(10*K + 4096);
        los = 1'b1;
        at_edge(10*K + 4098);
        chk(lol, 0, "R5 not before latency");
        at_edge(10*K + 4099);
        chk(lol, 1, "R5 los forces training"); chk(sel, 1, "R7 sel held mid-window");
        at_edge(10*K + 4106);
        los = 1'b0;
        at_edge(11*K);
        chk(sel, 0, "R7 sel at boundary");
        at_edge(12*K);
        chk(mode, 1, "R3 relock 3");
        at_edge(12*K + 2000);
        line_on = 0;
        at_edge(12*K + 2040);
        chk(lol, 0, "R6 not yet timed out");
        at_edge(12*K + 2080);
        chk(lol, 1, "R6 timeout"); chk(mode, 0, "R8 mode in training");
        at_edge(13*K + 2);
        chk(sel, 0, "R7 sel after timeout");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule